// File: doc/BRIEF.md
# Shared-Bus Arbiter with Burst-Locking DMA Channel Selection

This block decides, one bus cycle at a time, which of four masters owns a shared bus: the memory refresh engine, an external hold requester, the DMA engine and the CPU. The CPU owns the bus whenever no other master wants it. The block also selects which DMA channel the DMA engine serves. Each channel holds a pending request bit, an enable and a remaining-transfer count that the block decrements as transfers complete.

Ownership is re-evaluated only on the clock edge where `cycle_done` is high, so a bus cycle that has started always finishes. A channel in burst mode keeps the DMA engine to itself once accepted. Other channels are refused until its count runs out or it is stopped, and this includes channels with a lower index. Refresh and hold can still take the bus between two of its transfers. The burst then continues on the same channel once they release the bus. A channel in cycle-steal mode does one transfer per accepted request, and the bus then goes back to the CPU for at least one cycle.

There is no data stream at the edge of this block. Every pin is a plain control or status level, so no valid/ready handshake applies.

Top module: `bus_master_arbiter`

## Requirements
- R1: After reset the CPU holds the grant. Exactly one of the four grant outputs is high at all times. At each bus-cycle boundary the next owner is refresh if `refresh_req` is high, else hold if `hold_req` is high, else the DMA engine if a channel qualifies, else the CPU.
- R2: The grant outputs and `dma_ch` change only on a clock edge where `cycle_done` is high. Request, enable and terminate changes between boundaries leave them unchanged.
- R3: A one-cycle pulse on `ch_req[i]` while `ch_en[i]` is high marks channel i pending from the next cycle. When no channel is locked, the lowest-numbered pending, enabled channel with a nonzero count is chosen.
- R4: `ch_steal[i]` = 0 selects burst mode and 1 selects cycle-steal mode. A burst-mode channel granted the DMA engine becomes locked.
- R5: While a channel is locked, no other channel is granted the DMA engine, even one with a lower index that is pending.
- R6: If refresh or hold takes the bus from a locked channel, the next boundary that goes to DMA serves the same channel. Its count continues from where it stopped.
- R7: Each boundary that ends a DMA bus cycle decrements the served channel's count. When the count reaches zero, the channel's pending bit and the lock are cleared. Arbitration at that same boundary may then grant another channel.
- R8: `term_n` low at a boundary that ends a DMA bus cycle forcibly ends the served channel's request and lock. That channel is not regranted until it is requested again.
- R9: Clearing `ch_en[i]` drops channel i's pending bit and any lock it holds. From the next boundary on, channel i is not granted.
- R10: In cycle-steal mode a channel does one transfer per request. The boundary that ends that transfer grants refresh, hold or the CPU, never DMA.
- R11: A pulse on `cnt_wr[i]` loads `cnt_wdata` into channel i's count, and a load takes precedence over a decrement. A channel whose count is zero is never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| refresh_req | input | 1 | Memory refresh wants the bus |
| hold_req | input | 1 | External hold requester wants the bus |
| ch_req | input | NUM_CH | Per-channel request pulses |
| ch_en | input | NUM_CH | Per-channel enable |
| ch_steal | input | NUM_CH | Per-channel mode: 0 burst, 1 cycle steal |
| cnt_wr | input | NUM_CH | Per-channel count load strobe |
| cnt_wdata | input | CNT_W | Count value to load |
| term_n | input | 1 | Active-low terminate, sampled at DMA cycle ends |
| cycle_done | input | 1 | Current bus cycle ends on this edge |
| gnt_refresh | output | 1 | Refresh owns the bus |
| gnt_hold | output | 1 | Hold requester owns the bus |
| gnt_dma | output | 1 | DMA engine owns the bus |
| gnt_cpu | output | 1 | CPU owns the bus |
| dma_ch | output | $clog2(NUM_CH) | Channel served by the DMA engine |

## Verification
The hardest state to reach is a locked burst channel that is preempted mid-transfer while a lower-numbered channel waits. The bench has to confirm that the burst resumes on its own channel, with exactly the right number of transfers left, and then hands over cleanly. A directed sequence reaches this state. It loads counts, starts a burst on channel 2, and posts a request on channel 0. It then inserts refresh and hold preemptions at chosen boundaries and counts the decrements up to completion. The result is checked at every boundary against arithmetically expected owners. A sweep over all fifteen request patterns in cycle-steal mode covers the priority order and the CPU gap after each transfer.

// File: rtl/bma_pkg.sv
package bma_pkg;
  typedef enum logic [1:0] {
    OWN_CPU  = 2'd0,
    OWN_DMA  = 2'd1,
    OWN_HOLD = 2'd2,
    OWN_REFR = 2'd3
  } owner_t;
endpackage

// File: rtl/bma_chan.sv
module bma_chan #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             en,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             dec,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic             elig
);
  logic pend_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (!en) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~clr) | req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (wr) begin
      cnt_q <= wdata;
    end else if (dec && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt  = cnt_q;
  assign elig = pend_q & en & (cnt_q != '0);
endmodule

// File: rtl/bma_pick.sv
module bma_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  vec,
  output logic          vld,
  output logic [IW-1:0] idx
);
  always_comb begin
    vld = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        vld = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/bus_master_arbiter.sv
module bus_master_arbiter
  import bma_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 8,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              refresh_req,
  input  logic              hold_req,
  input  logic [NUM_CH-1:0] ch_req,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic [NUM_CH-1:0] ch_steal,
  input  logic [NUM_CH-1:0] cnt_wr,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic              term_n,
  input  logic              cycle_done,
  output logic              gnt_refresh,
  output logic              gnt_hold,
  output logic              gnt_dma,
  output logic              gnt_cpu,
  output logic [CH_W-1:0]   dma_ch
);
  owner_t owner_q, owner_nxt;
  logic [CH_W-1:0] act_q, dma_sel, pick_idx;
  logic lock_vld_q;

  logic [NUM_CH-1:0][CNT_W-1:0] cnt_all;
  logic [NUM_CH-1:0] elig, elig_next, clr_vec, dec_vec;
  logic dma_cycle_end, act_steal, act_last, forced, end_serv;
  logic lock_keep, pick_vld, steal_gap, dma_want;

  assign dma_cycle_end = cycle_done && (owner_q == OWN_DMA);
  assign act_steal     = ch_steal[act_q];
  assign act_last      = (cnt_all[act_q] <= CNT_W'(1));
  assign forced        = dma_cycle_end && !term_n;
  assign end_serv      = dma_cycle_end && (act_steal || act_last || forced);
  assign clr_vec       = end_serv ? (NUM_CH'(1) << act_q) : '0;
  assign dec_vec       = dma_cycle_end ? (NUM_CH'(1) << act_q) : '0;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    bma_chan #(.CNT_W(CNT_W)) u_chan (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (ch_req[g]),
      .en    (ch_en[g]),
      .wr    (cnt_wr[g]),
      .wdata (cnt_wdata),
      .dec   (dec_vec[g]),
      .clr   (clr_vec[g]),
      .cnt   (cnt_all[g]),
      .elig  (elig[g])
    );
  end

  assign elig_next = elig & ~clr_vec;

  bma_pick #(.N(NUM_CH), .IW(CH_W)) u_pick (
    .vec (elig_next),
    .vld (pick_vld),
    .idx (pick_idx)
  );

  assign lock_keep = lock_vld_q && elig_next[act_q];
  assign steal_gap = dma_cycle_end && act_steal;
  assign dma_want  = lock_keep || (pick_vld && !steal_gap);
  assign dma_sel   = lock_keep ? act_q : pick_idx;

  always_comb begin
    if (refresh_req)   owner_nxt = OWN_REFR;
    else if (hold_req) owner_nxt = OWN_HOLD;
    else if (dma_want) owner_nxt = OWN_DMA;
    else               owner_nxt = OWN_CPU;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q    <= OWN_CPU;
      act_q      <= '0;
      lock_vld_q <= 1'b0;
    end else if (cycle_done) begin
      owner_q <= owner_nxt;
      if (owner_nxt == OWN_DMA) begin
        act_q      <= dma_sel;
        lock_vld_q <= !ch_steal[dma_sel];
      end else begin
        lock_vld_q <= lock_keep;
      end
    end else begin
      lock_vld_q <= lock_vld_q && ch_en[act_q];
    end
  end

  assign gnt_refresh = (owner_q == OWN_REFR);
  assign gnt_hold    = (owner_q == OWN_HOLD);
  assign gnt_dma     = (owner_q == OWN_DMA);
  assign gnt_cpu     = (owner_q == OWN_CPU);
  assign dma_ch      = act_q;
endmodule

// File: rtl/bma_checker.sv
module bma_checker #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              refresh_req,
  input logic              hold_req,
  input logic              cycle_done,
  input logic              term_n,
  input logic [NUM_CH-1:0] ch_steal,
  input logic              gnt_refresh,
  input logic              gnt_hold,
  input logic              gnt_dma,
  input logic              gnt_cpu,
  input logic [CH_W-1:0]   dma_ch
);
  assert_one_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({gnt_refresh, gnt_hold, gnt_dma, gnt_cpu}) == 1);

  assert_refresh_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done && refresh_req |=> gnt_refresh);

  assert_hold_second_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done && !refresh_req && hold_req |=> gnt_hold);

  assert_grant_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cycle_done |=> $stable({gnt_refresh, gnt_hold, gnt_dma, gnt_cpu, dma_ch}));

  assert_steal_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done && gnt_dma && ch_steal[dma_ch] |=> !gnt_dma);

  assert_term_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done && gnt_dma && !term_n |=> !(gnt_dma && dma_ch == $past(dma_ch)));
endmodule

bind bus_master_arbiter bma_checker #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_bma_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .refresh_req (refresh_req),
  .hold_req    (hold_req),
  .cycle_done  (cycle_done),
  .term_n      (term_n),
  .ch_steal    (ch_steal),
  .gnt_refresh (gnt_refresh),
  .gnt_hold    (gnt_hold),
  .gnt_dma     (gnt_dma),
  .gnt_cpu     (gnt_cpu),
  .dma_ch      (dma_ch)
);

// File: tb/bus_master_arbiter_bench.sv
`timescale 1ns/1ps
module bus_master_arbiter_bench;
  localparam int NCH = 4;
  localparam int CW  = 8;
  localparam int OWN_CPU = 0, OWN_DMA = 1, OWN_HOLD = 2, OWN_REF = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic refresh_req = 1'b0, hold_req = 1'b0;
  logic [NCH-1:0] ch_req = '0, ch_en = '1, ch_steal = '0, cnt_wr = '0;
  logic [CW-1:0] cnt_wdata = '0;
  logic term_n = 1'b1, cycle_done = 1'b0;
  logic gnt_refresh, gnt_hold, gnt_dma, gnt_cpu;
  logic [1:0] dma_ch;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  bus_master_arbiter #(.NUM_CH(NCH), .CNT_W(CW)) u_bus_master_arbiter (
    .clk(clk), .rst_n(rst_n), .refresh_req(refresh_req), .hold_req(hold_req),
    .ch_req(ch_req), .ch_en(ch_en), .ch_steal(ch_steal), .cnt_wr(cnt_wr),
    .cnt_wdata(cnt_wdata), .term_n(term_n), .cycle_done(cycle_done),
    .gnt_refresh(gnt_refresh), .gnt_hold(gnt_hold), .gnt_dma(gnt_dma),
    .gnt_cpu(gnt_cpu), .dma_ch(dma_ch)
  );

  function automatic int owner_now();
    if ({gnt_refresh, gnt_hold, gnt_dma, gnt_cpu} == 4'b1000) return OWN_REF;
    if ({gnt_refresh, gnt_hold, gnt_dma, gnt_cpu} == 4'b0100) return OWN_HOLD;
    if ({gnt_refresh, gnt_hold, gnt_dma, gnt_cpu} == 4'b0010) return OWN_DMA;
    if ({gnt_refresh, gnt_hold, gnt_dma, gnt_cpu} == 4'b0001) return OWN_CPU;
    return -1;
  endfunction

  function automatic int lowest(int m);
    for (int i = 0; i < NCH; i++) if ((m >> i) & 1) return i;
    return -1;
  endfunction

  task automatic expect_own(string rq, int own, int ch);
    int a_own, a_key, e_key;
    a_own = owner_now();
    a_key = a_own * 16 + ((a_own == OWN_DMA) ? int'(dma_ch) : 0);
    e_key = own * 16 + ((own == OWN_DMA) ? ch : 0);
    n_tests++;
    if (a_key != e_key) begin
      n_fail++;
      $display("FAIL %s: owner/ch actual %0d/%0d expected %0d/%0d",
               rq, a_own, dma_ch, own, ch);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic boundary();
    cycle_done = 1'b1;
    tick();
    cycle_done = 1'b0;
  endtask

  task automatic pulse_req(int m);
    ch_req = NCH'(m);
    tick();
    ch_req = '0;
  endtask

  task automatic load_cnt(int m, int v);
    cnt_wr = NCH'(m);
    cnt_wdata = CW'(v);
    tick();
    cnt_wr = '0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    expect_own("R1 reset", OWN_CPU, 0);

    // R2: requests without a boundary leave the grant alone
    refresh_req = 1'b1;
    tick(); tick(); tick();
    expect_own("R2 no boundary", OWN_CPU, 0);
    boundary();
    expect_own("R1 refresh", OWN_REF, 0);
    refresh_req = 1'b0; hold_req = 1'b1;
    boundary();
    expect_own("R1 hold", OWN_HOLD, 0);
    hold_req = 1'b0;
    boundary();
    expect_own("R1 idle cpu", OWN_CPU, 0);

    // R3 R10: sweep every request pattern in cycle-steal mode
    ch_steal = '1;
    for (int p = 1; p < 16; p++) begin
      int rem;
      load_cnt(15, 3);
      pulse_req(p);
      rem = p;
      while (rem != 0) begin
        int lo;
        lo = lowest(rem);
        boundary();
        expect_own("R3 lowest pending", OWN_DMA, lo);
        boundary();
        rem = rem & ~(1 << lo);
        expect_own("R10 cpu gap", OWN_CPU, 0);
      end
    end

    // R11: zero count is never granted
    ch_steal = '0;
    load_cnt(8, 0);
    pulse_req(8);
    boundary();
    expect_own("R11 zero count", OWN_CPU, 0);
    ch_en[3] = 1'b0; tick(); ch_en[3] = 1'b1; tick();

    // R4 R5 R6 R7 R8: burst lock sequence
    load_cnt(4, 3);
    load_cnt(1, 4);
    pulse_req(4);
    boundary();
    expect_own("R4 burst grant", OWN_DMA, 2);
    pulse_req(1);
    boundary();
    expect_own("R5 lock holds vs ch0", OWN_DMA, 2);
    refresh_req = 1'b1;
    boundary();
    expect_own("R6 refresh preempts", OWN_REF, 0);
    boundary();
    expect_own("R6 refresh stays", OWN_REF, 0);
    refresh_req = 1'b0;
    boundary();
    expect_own("R6 resume ch2", OWN_DMA, 2);
    boundary();
    expect_own("R7 count done, ch0 next", OWN_DMA, 0);
    hold_req = 1'b1;
    boundary();
    expect_own("R6 hold preempts", OWN_HOLD, 0);
    hold_req = 1'b0;
    boundary();
    expect_own("R6 resume ch0", OWN_DMA, 0);
    term_n = 1'b0;
    boundary();
    term_n = 1'b1;
    expect_own("R8 forced end", OWN_CPU, 0);
    boundary();
    expect_own("R8 no regrant", OWN_CPU, 0);

    // R9: enable cleared mid-burst
    load_cnt(2, 5);
    pulse_req(2);
    boundary();
    expect_own("R9 grant ch1", OWN_DMA, 1);
    boundary();
    expect_own("R9 burst ch1", OWN_DMA, 1);
    ch_en[1] = 1'b0;
    tick();
    expect_own("R2 enable drop no boundary", OWN_DMA, 1);
    boundary();
    expect_own("R9 disabled released", OWN_CPU, 0);
    ch_en[1] = 1'b1;
    tick();
    boundary();
    expect_own("R9 request dropped", OWN_CPU, 0);

    // R7 R11: load beats decrement, count of 1 gives exactly one transfer
    load_cnt(8, 1);
    pulse_req(8);
    boundary();
    expect_own("R11 loaded ch3", OWN_DMA, 3);
    boundary();
    expect_own("R7 single transfer done", OWN_CPU, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule